// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

An 18-bit, non-inverting bus transceiver with a separate storage path for each direction. One path carries the A side to the B side, the other carries B to A. Each path has its own output enable, its own mode control and its own strobe. The mode control picks between two behaviours. When it is high, the path is a transparent latch and the far side follows the near side. When it is low, the path is an edge-captured register that loads on a high-to-low transition of its strobe and otherwise holds its value.

The block sits inside a synchronous design. Every input is sampled on the rising edge of `clk`, so a strobe transition counts when the strobe is seen high at one rising edge and low at the next. Each bus side is modelled as an input vector, a driven-value vector and a per-bit enable vector, ready for a pad ring to join into a tristate pin. The A-to-B enable is active high and the B-to-A enable is active low. An asynchronous active-low reset stands in for power-up. It empties both stores and keeps every output enable off for as long as it is held.

Top module: `ubt_xcvr`

## Requirements
- R1: Each path is W = 18 bits wide and passes data without inversion. Bit i of the source side appears on bit i of the far side, for all-ones, alternating and single-bit patterns.
- R2: While `le_ab` is high, `b_out` equals `a_in` in the same cycle, and the A-to-B store loads `a_in` at every rising edge of `clk`.
- R3: While `le_ab` is low, a rising `clk` edge at which `cp_ab` is sampled low, after being sampled high at the edge before, loads `a_in` into the store. From that edge on, `b_out` shows the loaded value.
- R4: While `le_ab` is low and no such falling strobe is seen, the store and `b_out` keep their value whatever `a_in` does.
- R5: `b_oe` is all ones when `oe_ab` is 1 and reset is released, and all zeros otherwise. `b_out` presents the selected value regardless of the enable.
- R6: The B-to-A path behaves like R2 to R4, using `le_ba`, `cp_ba` and `b_in` to produce `a_out`. `a_oe` is all ones when `oe_ba_n` is 0 and reset is released, and all zeros otherwise.
- R7: Each store keeps latching and capturing while its outputs are disabled. When the enable is next asserted, the output presents the stored value in that same cycle.
- R8: While `rst_n` is low, both enable vectors are zero and both stores are cleared to zero at once. The strobe history is also cleared, so a strobe held high through reset release causes no capture at the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| oe_ab | input | 1 | B-side output enable, active high |
| oe_ba_n | input | 1 | A-side output enable, active low |
| le_ab | input | 1 | A-to-B mode: 1 transparent, 0 edge-captured |
| le_ba | input | 1 | B-to-A mode: 1 transparent, 0 edge-captured |
| cp_ab | input | 1 | A-to-B capture strobe, acts on its falling transition |
| cp_ba | input | 1 | B-to-A capture strobe, acts on its falling transition |
| a_in | input | 18 | Value received from the A bus |
| b_in | input | 18 | Value received from the B bus |
| a_out | output | 18 | Value to drive onto the A bus |
| a_oe | output | 18 | Per-bit drive enable for the A bus |
| b_out | output | 18 | Value to drive onto the B bus |
| b_oe | output | 18 | Per-bit drive enable for the B bus |

## Verification
Results arrive with two different delays:
- The transparent path and both enables are combinational, so they are due in the same cycle as the stimulus.
- A strobe capture or a hold appears on the output only after the rising `clk` edge that samples the falling strobe, one edge after the stimulus.

The bench changes inputs on the falling edge and compares against its model at the next falling edge. By then exactly one rising edge has passed, and the values it compares are settled for both the combinational and the registered results.

// File: rtl/ubt_xcvr.sv
module ubt_xcvr #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         oe_ab,
  input  logic         oe_ba_n,
  input  logic         le_ab,
  input  logic         le_ba,
  input  logic         cp_ab,
  input  logic         cp_ba,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);

  logic [W-1:0] st_ab, st_ba;
  logic         cpq_ab, cpq_ba;
  logic         ld_ab, ld_ba;

  assign ld_ab = le_ab | (cpq_ab & ~cp_ab);
  assign ld_ba = le_ba | (cpq_ba & ~cp_ba);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_ab  <= '0;
      cpq_ab <= 1'b0;
    end else begin
      cpq_ab <= cp_ab;
      if (ld_ab) st_ab <= a_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_ba  <= '0;
      cpq_ba <= 1'b0;
    end else begin
      cpq_ba <= cp_ba;
      if (ld_ba) st_ba <= b_in;
    end
  end

  assign b_out = le_ab ? a_in : st_ab;
  assign a_out = le_ba ? b_in : st_ba;

  assign b_oe = {W{oe_ab & rst_n}};
  assign a_oe = {W{~oe_ba_n & rst_n}};

endmodule

// File: rtl/ubt_xcvr_chk.sv
module ubt_xcvr_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic         oe_ab,
  input logic         oe_ba_n,
  input logic         le_ab,
  input logic         le_ba,
  input logic         cp_ab,
  input logic         cp_ba,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] a_oe,
  input logic [W-1:0] b_out,
  input logic [W-1:0] b_oe
);

  logic         cq_ab, cq_ba;
  logic         cap_ab_q, cap_ba_q, hold_ab_q, hold_ba_q;
  logic [W-1:0] ain_q, bin_q, bout_q, aout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cq_ab <= 1'b0; cq_ba <= 1'b0;
      cap_ab_q <= 1'b0; cap_ba_q <= 1'b0;
      hold_ab_q <= 1'b0; hold_ba_q <= 1'b0;
      ain_q <= '0; bin_q <= '0; bout_q <= '0; aout_q <= '0;
    end else begin
      cq_ab <= cp_ab;
      cq_ba <= cp_ba;
      cap_ab_q  <= !le_ab && cq_ab && !cp_ab;
      cap_ba_q  <= !le_ba && cq_ba && !cp_ba;
      hold_ab_q <= !le_ab && !(cq_ab && !cp_ab);
      hold_ba_q <= !le_ba && !(cq_ba && !cp_ba);
      ain_q  <= a_in;
      bin_q  <= b_in;
      bout_q <= b_out;
      aout_q <= a_out;
    end
  end

  a_r2_follow: assert property (@(posedge clk) disable iff (!rst_n)
    le_ab |-> b_out == a_in);
  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_ab && cap_ab_q) |-> b_out == ain_q);
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_ab && hold_ab_q) |-> b_out == bout_q);
  a_r5_b_enable: assert property (@(posedge clk) disable iff (!rst_n)
    oe_ab |-> (&b_oe));
  a_r5_b_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_ab |-> b_oe == '0);
  a_r6_follow: assert property (@(posedge clk) disable iff (!rst_n)
    le_ba |-> a_out == b_in);
  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_ba && cap_ba_q) |-> a_out == bin_q);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_ba && hold_ba_q) |-> a_out == aout_q);
  a_r6_a_disable: assert property (@(posedge clk) disable iff (!rst_n)
    oe_ba_n |-> a_oe == '0);
  a_r8_reset_off: assert property (@(posedge clk)
    !rst_n |-> (a_oe == '0 && b_oe == '0));

endmodule

bind ubt_xcvr ubt_xcvr_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .oe_ab(oe_ab), .oe_ba_n(oe_ba_n),
  .le_ab(le_ab), .le_ba(le_ba), .cp_ab(cp_ab), .cp_ba(cp_ba),
  .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
  .b_out(b_out), .b_oe(b_oe)
);

// File: tb/ubt_xcvr_tb_top.sv
`timescale 1ns/1ps
module ubt_xcvr_tb_top;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oe_ab = 1'b0, oe_ba_n = 1'b1, le_ab = 1'b1, le_ba = 1'b1;
  logic cp_ab = 1'b1, cp_ba = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ubt_xcvr #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .oe_ab(oe_ab), .oe_ba_n(oe_ba_n),
    .le_ab(le_ab), .le_ba(le_ba), .cp_ab(cp_ab), .cp_ba(cp_ba),
    .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
    .b_out(b_out), .b_oe(b_oe)
  );

  // behavioural reference: stored words and last seen strobe levels
  logic [W-1:0] m_ab, m_ba;
  logic m_cpab, m_cpba, m_capab, m_capba;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ab <= 0; m_ba <= 0; m_cpab <= 0; m_cpba <= 0; m_capab <= 0; m_capba <= 0;
    end else begin
      m_capab <= (le_ab == 0) && (m_cpab == 1) && (cp_ab == 0);
      m_capba <= (le_ba == 0) && (m_cpba == 1) && (cp_ba == 0);
      if (le_ab == 1 || (m_cpab == 1 && cp_ab == 0)) m_ab <= a_in;
      if (le_ba == 1 || (m_cpba == 1 && cp_ba == 0)) m_ba <= b_in;
      m_cpab <= cp_ab;
      m_cpba <= cp_ba;
    end
  end

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp();
    logic [W-1:0] eb, ea;
    eb = le_ab ? a_in : m_ab;
    ea = le_ba ? b_in : m_ba;
    chk(!rst_n ? "R8 b_oe" : "R5 b_oe", b_oe, (oe_ab && rst_n) ? '1 : '0);
    chk(!rst_n ? "R8 a_oe" : "R6 a_oe", a_oe, (!oe_ba_n && rst_n) ? '1 : '0);
    chk(le_ab ? "R2 b_out" : (m_capab ? "R3 b_out" : "R4 b_out"), b_out, eb);
    chk(le_ba ? "R6 a_out follow" : "R6 a_out stored", a_out, ea);
    if (oe_ab && !oe_ba_n) chk("R6 stimulus both enabled", 1, 0);
  endtask

  task automatic step();
    @(negedge clk);
    cmp();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] lf;
    lf = 32'h1234_5678;
    // R8: reset holds enables off even when requested
    oe_ab = 1; oe_ba_n = 1; a_in = 18'h0abcd;
    step(); step();
    chk("R8 b_oe in reset", b_oe, '0);
    // release with strobe held high and capture mode
    le_ab = 0; le_ba = 0;
    step();
    @(negedge clk); #1 rst_n = 1;
    a_in = 18'h3ffff; b_in = 18'h3ffff;
    step(); step();
    chk("R8 no capture after release", b_out, '0);

    // R1 patterns through the transparent path
    le_ab = 1;
    a_in = 18'h3ffff; step(); chk("R1 all ones", b_out, 18'h3ffff);
    a_in = 18'h2aaaa; step(); chk("R1 alternating", b_out, 18'h2aaaa);
    a_in = 18'h15555; step(); chk("R1 alternating inv", b_out, 18'h15555);
    a_in = 18'h00001; step(); chk("R1 single bit", b_out, 18'h00001);
    a_in = 18'h20000; step(); chk("R2 msb", b_out, 18'h20000);

    // R3 capture on falling strobe
    le_ab = 0; cp_ab = 1; a_in = 18'h01234; step();
    cp_ab = 0; a_in = 18'h0beef; step(); chk("R3 capture", b_out, 18'h0beef);
    // R4 hold with steady strobe
    a_in = 18'h11111; step(); chk("R4 hold low", b_out, 18'h0beef);
    cp_ab = 1; a_in = 18'h22222; step(); chk("R4 hold rising", b_out, 18'h0beef);

    // R7 capture while disabled then enable
    oe_ab = 0; a_in = 18'h0c0de; cp_ab = 0; step();
    chk("R5 disabled", b_oe, '0);
    a_in = 18'h33333; oe_ab = 1; step();
    chk("R7 shows stored", b_out, 18'h0c0de);
    chk("R7 enabled", b_oe, '1);

    // B-to-A direction
    oe_ab = 0; oe_ba_n = 0; le_ba = 1; b_in = 18'h2f00f; step();
    chk("R6 follow", a_out, 18'h2f00f);
    chk("R6 enable low active", a_oe, '1);
    le_ba = 0; cp_ba = 1; step();
    cp_ba = 0; b_in = 18'h05a5a; step(); chk("R6 capture", a_out, 18'h05a5a);
    b_in = 18'h00000; step(); chk("R6 hold", a_out, 18'h05a5a);
    oe_ba_n = 1; step(); chk("R6 disabled", a_oe, '0);

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      a_in = lf[17:0];
      b_in = lf[31:14];
      cp_ab = lf[20]; cp_ba = lf[21];
      le_ab = (lf[24:22] == 0); le_ba = (lf[27:25] == 0);
      oe_ab = lf[28];
      oe_ba_n = lf[28] ? 1'b1 : lf[29];
      step();
    end

    // R8 asynchronous reset mid-run clears the stores
    le_ab = 0; le_ba = 0; cp_ab = 1; cp_ba = 1; oe_ab = 1; oe_ba_n = 1;
    a_in = 18'h3ffff; step(); cp_ab = 0; step();
    #1 rst_n = 0; #1;
    chk("R8 async b_oe", b_oe, '0);
    chk("R8 async clear", b_out, '0);
    step();
    @(negedge clk); #1 rst_n = 1;
    step();
    chk("R8 cleared after release", b_out, '0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule